// File: doc/BRIEF.md
# Ring-Following Peripheral DMA Channel

This block is one DMA channel that moves data between a memory buffer and a fixed peripheral data register. Software places a ring of link descriptors in memory. Each descriptor holds a source address, a destination address, a byte count and the address of the next descriptor. Software loads the address of the first descriptor and sets the start bit. From then on the channel fetches a descriptor, copies its byte count, flags the end of the segment and moves to the next descriptor. Because the last descriptor points back to the first, the transfer keeps running without any restart from software.

One side of the copy can be pinned to a fixed address, which is how a peripheral FIFO register is targeted. Accesses are 1, 2 or 4 bytes wide on a 32-bit word port with byte enables. The byte lane of each access comes from the low address bits, so a narrow sample can sit in any lane of the peripheral word. When external pacing is enabled, a peripheral request line lets the channel move one burst of a programmed power-of-two size and then makes it wait for the next request. The channel can therefore be armed well before the peripheral needs data.

The controller is a state machine with these states:
- `S_IDLE`: after reset.
- `S_FETCH`: four descriptor word reads.
- `S_CHECK`: descriptor validation.
- `S_WAIT`: waits for a burst grant.
- `S_READ`: one source access.
- `S_WRITE`: one destination access.
- `S_SEGEND`: descriptor done.
- `S_HALT`: stopped after an error or an abort.

The transitions are:
- start: `S_IDLE` or `S_HALT` to `S_FETCH`.
- fetch done: `S_FETCH` to `S_CHECK`.
- bad descriptor: `S_CHECK` to `S_HALT`.
- good descriptor: `S_CHECK` to `S_WAIT`.
- grant: `S_WAIT` to `S_READ`.
- read done: `S_READ` to `S_WRITE`.
- burst continue: `S_WRITE` to `S_READ`.
- burst end: `S_WRITE` to `S_WAIT`.
- count done: `S_WRITE` to `S_SEGEND`.
- follow link: `S_SEGEND` to `S_FETCH`.
- abort: any busy state to `S_HALT`.

Top module: `chdma_top`

## Requirements
- R1: After reset the status register reads 0, `irq` is low, `mem_req` is low and the live source register (register 3) reads 0.
- R2: A descriptor is four words at byte offsets +0 source, +4 destination, +8 byte count and +12 next-descriptor address, and the channel fetches them in that order. After each descriptor completes, the channel fetches the descriptor at its next address. A ring of descriptors therefore repeats for as long as the channel runs.
- R3: Mode bit 5 (destination hold) keeps the destination address fixed for every access while the source advances by the access size.
- R4: Mode bit 6 (source hold) keeps the source address fixed while the destination advances by the access size.
- R5: Mode bits [9:8] select the access size: code 0 is 1 byte, code 1 is 2 bytes and code 2 is 4 bytes. Data is taken from the source word lanes starting at source address bits [1:0] and placed at the destination lanes starting at destination address bits [1:0], with byte enables set only on the lanes written. Code 3 is reported as a programming error.
- R6: Mode bits [13:10] give the burst length as 2 to that power, in bytes. When mode bit 4 (pacing) is set, the channel moves nothing while `periph_req` is low. Each cycle in which `periph_req` is seen high while waiting releases exactly one burst.
- R7: Completing a descriptor sets status bit 0 (segment end). `irq` is high while that bit and mode bit 2 are both set.
- R8: A fetched descriptor with a byte count of 0 or a next address of 0 sets status bit 1 (programming error) and halts the channel. `irq` reflects this bit only when mode bit 3 is set.
- R9: Writing 1 to status bit 0 or bit 1 clears that bit, and writing 0 leaves it unchanged.
- R10: Writing mode bit 1 (abort) while the channel is busy halts it on the next cycle. Status bit 3 then reads 1 and bit 2 reads 0, and no further memory access occurs.
- R11: Registers 3, 4 and 5 read the live source address, destination address and remaining byte count, which advance after each write access. Register 2 reads the current descriptor address.
- R12: Writing mode bit 0 (start) in the idle or halted state begins fetching at the address held in register 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 mode, 1 status, 2 descriptor, 3 source, 4 destination, 5 count |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte enables for a write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data for `mem_addr`, same cycle |
| periph_req | input | 1 | Peripheral burst request |
| irq | output | 1 | Interrupt request |

## Verification
After a start write, four fetch cycles and one check cycle pass before the first grant cycle. Each data access then takes a read cycle followed by a write cycle, so a memory write lands two cycles after the grant. A segment-end flag is visible one cycle after the final write, and an abort shows as halted on the cycle after the write strobe. The bench never samples at a fixed offset for data. It waits, with a bound, for a count of observed memory writes, and it reads registers and `irq` half a cycle after the edge so that every flag has settled. Pacing is checked by holding the request low for many cycles and then giving single-cycle pulses, each followed by a settling window before the write count is read.

// File: rtl/chdma_pkg.sv
package chdma_pkg;

    localparam int BLG_W = 4;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_CHECK, S_WAIT, S_READ, S_WRITE, S_SEGEND, S_HALT
    } chdma_state_t;

    localparam logic [2:0] RA_MODE = 3'd0;
    localparam logic [2:0] RA_STAT = 3'd1;
    localparam logic [2:0] RA_DESC = 3'd2;
    localparam logic [2:0] RA_SRC  = 3'd3;
    localparam logic [2:0] RA_DST  = 3'd4;
    localparam logic [2:0] RA_CNT  = 3'd5;

    typedef struct packed {
        logic [BLG_W-1:0] burst_lg;
        logic [1:0]       size;
        logic             src_hold;
        logic             dst_hold;
        logic             paced;
        logic             err_ie;
        logic             eos_ie;
    } chdma_mode_t;

endpackage

// File: rtl/chdma_lane.sv
module chdma_lane #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]           word_in,
    input  logic [$clog2(DW/8)-1:0] src_off,
    input  logic [$clog2(DW/8)-1:0] dst_off,
    input  logic [1:0]              size,
    output logic [DW-1:0]           word_out,
    output logic [DW/8-1:0]         lane_en
);
    localparam int NB = DW / 8;
    localparam int OW = $clog2(NB);

    logic [DW-1:0] picked;
    logic [DW-1:0] placed;
    logic [OW:0]   nbytes;

    always_comb begin
        nbytes = (OW+1)'(1) << size;
        picked = word_in >> {src_off, 3'b000};
        placed = picked << {dst_off, 3'b000};
    end

    for (genvar i = 0; i < NB; i++) begin : g_lane
        always_comb begin
            lane_en[i] = ((OW+1)'(i) >= {1'b0, dst_off}) &&
                         ((OW+1)'(i) < ({1'b0, dst_off} + nbytes));
            word_out[8*i +: 8] = lane_en[i] ? placed[8*i +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/chdma_ctrl.sv
module chdma_ctrl
    import chdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chdma_mode_t       mode,
    input  logic              start,
    input  logic              abort,
    input  logic              desc_we,
    input  logic [AW-1:0]     desc_wdata,
    input  logic              periph_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    input  logic [DW-1:0]     mem_rdata,
    output logic [DW-1:0]     word_q,
    output logic [AW-1:0]     src_q,
    output logic [AW-1:0]     dst_q,
    output logic [AW-1:0]     cnt_q,
    output logic [AW-1:0]     desc_q,
    output logic              busy,
    output logic              halted,
    output logic              eos_set,
    output logic              pe_set
);
    localparam int BLW = (2 ** BLG_W) + 1;

    chdma_state_t   st_q, st_d;
    logic [1:0]     idx_q;
    logic [AW-1:0]  next_q;
    logic [BLW-1:0] bleft_q;
    logic [3:0]     sz4;
    logic [AW-1:0]  sz;
    logic           last, burst_done, bad;

    always_comb begin
        sz4        = 4'd1 << mode.size;
        sz         = AW'(sz4);
        last       = cnt_q <= sz;
        burst_done = bleft_q <= BLW'(sz4);
        bad        = (next_q == '0) || (cnt_q == '0) || (mode.size == 2'd3);
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE, S_HALT: if (start) st_d = S_FETCH;
            S_FETCH:  if (idx_q == 2'd3) st_d = S_CHECK;
            S_CHECK:  st_d = bad ? S_HALT : S_WAIT;
            S_WAIT:   if (!mode.paced || periph_req) st_d = S_READ;
            S_READ:   st_d = S_WRITE;
            S_WRITE:  st_d = last ? S_SEGEND : (burst_done ? S_WAIT : S_READ);
            S_SEGEND: st_d = S_FETCH;
            default:  st_d = S_IDLE;
        endcase
        if (abort && (st_q != S_IDLE) && (st_q != S_HALT)) st_d = S_HALT;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // outputs decoded from state
    always_comb begin
        mem_req  = (st_q == S_FETCH) || (st_q == S_READ) || (st_q == S_WRITE);
        mem_we   = (st_q == S_WRITE);
        unique case (st_q)
            S_FETCH: mem_addr = desc_q + AW'({idx_q, 2'b00});
            S_READ:  mem_addr = {src_q[AW-1:2], 2'b00};
            S_WRITE: mem_addr = {dst_q[AW-1:2], 2'b00};
            default: mem_addr = '0;
        endcase
        busy    = (st_q != S_IDLE) && (st_q != S_HALT);
        halted  = (st_q == S_HALT);
        eos_set = (st_q == S_SEGEND);
        pe_set  = (st_q == S_CHECK) && bad;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            next_q  <= '0;
            bleft_q <= '0;
            word_q  <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            cnt_q   <= '0;
            desc_q  <= '0;
        end else begin
            unique case (st_q)
                S_FETCH: begin
                    unique case (idx_q)
                        2'd0: src_q  <= AW'(mem_rdata);
                        2'd1: dst_q  <= AW'(mem_rdata);
                        2'd2: cnt_q  <= AW'(mem_rdata);
                        2'd3: next_q <= AW'(mem_rdata);
                    endcase
                    idx_q <= idx_q + 2'd1;
                end
                S_WAIT:   bleft_q <= BLW'(1) << mode.burst_lg;
                S_READ:   word_q  <= mem_rdata;
                S_WRITE: begin
                    if (!mode.src_hold) src_q <= src_q + sz;
                    if (!mode.dst_hold) dst_q <= dst_q + sz;
                    cnt_q   <= last ? '0 : cnt_q - sz;
                    bleft_q <= bleft_q - BLW'(sz4);
                end
                S_SEGEND: desc_q <= next_q;
                default: ;
            endcase
            if (desc_we && !busy) desc_q <= desc_wdata;
            if (start && !busy)   idx_q  <= '0;
        end
    end

endmodule

// File: rtl/chdma_csr.sv
module chdma_csr
    import chdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    output chdma_mode_t   mode,
    output logic          start,
    output logic          abort,
    output logic          desc_we,
    input  logic          eos_set,
    input  logic          pe_set,
    input  logic          busy,
    input  logic          halted,
    input  logic [AW-1:0] src_q,
    input  logic [AW-1:0] dst_q,
    input  logic [AW-1:0] cnt_q,
    input  logic [AW-1:0] desc_q,
    output logic          eos_flag,
    output logic          irq
);
    logic mode_wr, stat_wr, pe_flag;

    always_comb begin
        mode_wr = reg_wr && (reg_addr == RA_MODE);
        stat_wr = reg_wr && (reg_addr == RA_STAT);
        desc_we = reg_wr && (reg_addr == RA_DESC);
        start   = mode_wr && reg_wdata[0];
        abort   = mode_wr && reg_wdata[1];
        irq     = (eos_flag && mode.eos_ie) || (pe_flag && mode.err_ie);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= '0;
            eos_flag <= 1'b0;
            pe_flag  <= 1'b0;
        end else begin
            if (mode_wr) begin
                mode.eos_ie   <= reg_wdata[2];
                mode.err_ie   <= reg_wdata[3];
                mode.paced    <= reg_wdata[4];
                mode.dst_hold <= reg_wdata[5];
                mode.src_hold <= reg_wdata[6];
                mode.size     <= reg_wdata[9:8];
                mode.burst_lg <= reg_wdata[10 +: BLG_W];
            end
            if (eos_set)                      eos_flag <= 1'b1;
            else if (stat_wr && reg_wdata[0]) eos_flag <= 1'b0;
            if (pe_set)                       pe_flag  <= 1'b1;
            else if (stat_wr && reg_wdata[1]) pe_flag  <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_MODE: reg_rdata = AW'({mode.burst_lg, mode.size, 1'b0, mode.src_hold,
                                      mode.dst_hold, mode.paced, mode.err_ie,
                                      mode.eos_ie, 2'b00});
            RA_STAT: reg_rdata = AW'({halted, busy, pe_flag, eos_flag});
            RA_DESC: reg_rdata = desc_q;
            RA_SRC:  reg_rdata = src_q;
            RA_DST:  reg_rdata = dst_q;
            RA_CNT:  reg_rdata = cnt_q;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/chdma_top.sv
module chdma_top
    import chdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [2:0]      reg_addr,
    input  logic [AW-1:0]   reg_wdata,
    output logic [AW-1:0]   reg_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW/8-1:0] mem_be,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            periph_req,
    output logic            irq
);
    localparam int OW = $clog2(DW / 8);

    chdma_mode_t   mode_w;
    logic          start_w, abort_w, desc_we_w;
    logic          busy_w, halted_w, eos_set_w, pe_set_w, eos_flag_w;
    logic [DW-1:0] word_w;
    logic [AW-1:0] src_w, dst_w, cnt_w, desc_w;

    chdma_csr #(.AW(AW)) u_csr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode(mode_w),
        .start(start_w), .abort(abort_w), .desc_we(desc_we_w),
        .eos_set(eos_set_w), .pe_set(pe_set_w), .busy(busy_w), .halted(halted_w),
        .src_q(src_w), .dst_q(dst_w), .cnt_q(cnt_w), .desc_q(desc_w),
        .eos_flag(eos_flag_w), .irq(irq)
    );

    chdma_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode_w), .start(start_w), .abort(abort_w),
        .desc_we(desc_we_w), .desc_wdata(reg_wdata), .periph_req(periph_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .word_q(word_w), .src_q(src_w), .dst_q(dst_w), .cnt_q(cnt_w), .desc_q(desc_w),
        .busy(busy_w), .halted(halted_w), .eos_set(eos_set_w), .pe_set(pe_set_w)
    );

    chdma_lane #(.DW(DW)) u_lane (
        .word_in(word_w), .src_off(src_w[OW-1:0]), .dst_off(dst_w[OW-1:0]),
        .size(mode_w.size), .word_out(mem_wdata), .lane_en(mem_be)
    );

endmodule

// File: rtl/chdma_chk.sv
module chdma_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_req,
    input logic busy,
    input logic halted,
    input logic abort_p,
    input logic pe_set,
    input logic eos_set,
    input logic eos_flag
);
    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req);

    // R10
    abort_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_p && busy) |=> halted);

    // R8
    pe_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pe_set |=> halted);

    // R7
    eos_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eos_set |=> eos_flag);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

endmodule

bind chdma_top chdma_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .busy(busy_w), .halted(halted_w),
    .abort_p(abort_w), .pe_set(pe_set_w), .eos_set(eos_set_w), .eos_flag(eos_flag_w)
);

// File: tb/chdma_top_tb.sv
`timescale 1ns/1ps
module chdma_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic        periph_req = 1'b0;
    logic        irq;

    localparam logic [7:0] PO_W = 8'(32'h380 >> 2);
    localparam logic [7:0] PI_W = 8'(32'h384 >> 2);

    logic [31:0] mem    [0:255];
    logic [31:0] shadow [0:255];
    logic [31:0] log_d  [0:63];
    logic [3:0]  log_be [0:63];
    int          log_n, wr_n, pin_k;
    logic        clr = 1'b0;
    logic        tb_we = 1'b0;
    logic [31:0] tb_a = 32'd0, tb_d = 32'd0;
    int          n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    chdma_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .periph_req(periph_req), .irq(irq)
    );

    assign mem_rdata = mem[mem_addr[9:2]];

    function automatic logic [31:0] pat(input int k);
        return {16'(k * 3 + 16'h1001), 16'(k ^ 16'h5A5A)};
    endfunction

    function automatic logic [31:0] mk(input bit st, input bit ab, input bit eie, input bit rie,
                                       input bit pc, input bit dh, input bit sh,
                                       input logic [1:0] sz, input logic [3:0] blg);
        return {18'd0, blg, sz, 1'b0, sh, dh, pc, rie, eie, ab, st};
    endfunction

    always @(posedge clk) begin
        if (tb_we) mem[tb_a[9:2]] <= tb_d;
        if (clr) begin
            log_n <= 0; wr_n <= 0; pin_k <= 0;
        end else begin
            if (mem_req && mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                wr_n <= wr_n + 1;
                if (mem_addr[9:2] == PO_W) begin
                    if (log_n < 64) begin
                        log_d[log_n]  <= mem_wdata;
                        log_be[log_n] <= mem_be;
                    end
                    log_n <= log_n + 1;
                end
            end
            if (mem_req && !mem_we && mem_addr[9:2] == PI_W) begin
                mem[PI_W] <= pat(pin_k + 1);
                pin_k <= pin_k + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        tb_we = 1'b1; tb_a = a; tb_d = d;
        shadow[a[9:2]] = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; clr = 1'b1; periph_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; clr = 1'b0;
        poke(32'h384, pat(0));
    endtask

    task automatic desc(input logic [31:0] at, input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] c, input logic [31:0] nx);
        poke(at, s); poke(at + 4, d); poke(at + 8, c); poke(at + 12, nx);
    endtask

    task automatic wait_cnt(input bit use_log, input int n);
        for (int i = 0; i < 2000; i++) begin
            if ((use_log ? log_n : wr_n) >= n) break;
            @(negedge clk);
        end
    endtask

    task automatic run_all();
        logic [31:0] v;
        int na, nb, ca, cb, n0;
        // R1 reset state
        do_reset();
        rd_reg(3'd1, v); chk("R1 status", v, 32'd0);
        rd_reg(3'd3, v); chk("R1 src reg", v, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);

        // R2 R3 R7 R9 R10: random ring, memory to peripheral, word size
        for (int r = 0; r < 3; r++) begin
            do_reset();
            ca = 4 * (1 + int'($urandom % 8)); cb = 4 * (1 + int'($urandom % 8));
            na = ca / 4; nb = cb / 4;
            for (int i = 0; i < na + nb; i++) poke(32'h100 + 32'(4 * i), $urandom);
            desc(32'h40, 32'h100, 32'h380, 32'(ca), 32'h50);
            desc(32'h50, 32'h100 + 32'(ca), 32'h380, 32'(cb), 32'h40);
            wr_reg(3'd2, 32'h40);
            wr_reg(3'd0, mk(1, 0, 1, 0, 0, 1, 0, 2'd2, 4'd4));
            wait_cnt(1, 2 * na + nb);
            wr_reg(3'd0, mk(0, 1, 1, 0, 0, 1, 0, 2'd2, 4'd4));
            for (int i = 0; i < 2 * na + nb; i++) begin
                int w;
                w = (i < na + nb) ? 64 + i : 64 + i - na - nb;
                chk("R2 R3 ring word", log_d[i], shadow[w]);
            end
            rd_reg(3'd1, v); chk("R10 R7 status halted+eos", v & 32'hD, 32'h9);
            chk("R7 irq on eos", {31'd0, irq}, 32'd1);
            n0 = log_n;
            repeat (20) @(negedge clk);
            chk("R10 no writes after abort", 32'(log_n), 32'(n0));
            wr_reg(3'd1, 32'h0);
            rd_reg(3'd1, v); chk("R9 write 0 keeps eos", v[0], 1'b1);
            wr_reg(3'd1, 32'h1);
            rd_reg(3'd1, v); chk("R9 eos cleared", v[0], 1'b0);
            chk("R7 irq low after clear", {31'd0, irq}, 32'd0);
        end

        // R4 R5 capture: source held at peripheral upper half, 2-byte accesses
        do_reset();
        desc(32'h40, 32'h386, 32'h200, 32'd8, 32'h50);
        desc(32'h50, 32'h386, 32'h208, 32'd6, 32'h40);
        wr_reg(3'd2, 32'h40);
        wr_reg(3'd0, mk(1, 0, 0, 0, 0, 0, 1, 2'd1, 4'd3));
        wait_cnt(0, 7);
        wr_reg(3'd0, mk(0, 1, 0, 0, 0, 0, 1, 2'd1, 4'd3));
        for (int j = 0; j < 7; j++) begin
            logic [31:0] e;
            e = pat(j);
            chk("R4 R5 halfword", {16'd0, mem[(32'h200 + 32'(2 * j)) >> 2][16 * (j & 1) +: 16]},
                {16'd0, e[31:16]});
        end
        rd_reg(3'd3, v); chk("R4 src held", v, 32'h386);

        // R5 R6 R11 paced byte transfers into lane 3
        do_reset();
        for (int i = 0; i < 6; i++) poke(32'h100 + 32'(4 * i), $urandom);
        desc(32'h40, 32'h100, 32'h383, 32'd12, 32'h50);
        desc(32'h50, 32'h10C, 32'h383, 32'd12, 32'h40);
        wr_reg(3'd2, 32'h40);
        wr_reg(3'd0, mk(1, 0, 0, 0, 1, 1, 0, 2'd0, 4'd2));
        repeat (40) @(negedge clk);
        chk("R6 stall without request", 32'(log_n), 32'd0);
        rd_reg(3'd3, v); chk("R11 src after fetch", v, 32'h100);
        for (int p = 1; p <= 2; p++) begin
            periph_req = 1'b1; @(negedge clk); periph_req = 1'b0;
            repeat (30) @(negedge clk);
            chk("R6 one burst per request", 32'(log_n), 32'(4 * p));
            rd_reg(3'd3, v); chk("R11 live src", v, 32'h100 + 32'(4 * p));
            rd_reg(3'd4, v); chk("R3 R11 dst held", v, 32'h383);
            rd_reg(3'd5, v); chk("R11 remaining count", v, 32'(12 - 4 * p));
        end
        for (int i = 0; i < 8; i++) begin
            logic [31:0] s;
            s = shadow[(32'h100 + 32'(i)) >> 2];
            chk("R5 byte lane 3 data", {24'd0, log_d[i][31:24]}, {24'd0, s[8 * (i & 3) +: 8]});
            chk("R5 byte enable", {28'd0, log_be[i]}, 32'h8);
        end

        // R8 R9 zero count with error interrupt on
        do_reset();
        desc(32'h40, 32'h100, 32'h380, 32'd0, 32'h50);
        wr_reg(3'd2, 32'h40);
        wr_reg(3'd0, mk(1, 0, 0, 1, 0, 1, 0, 2'd2, 4'd2));
        repeat (10) @(negedge clk);
        rd_reg(3'd1, v); chk("R8 zero count halts", v, 32'hA);
        chk("R8 irq with err enable", {31'd0, irq}, 32'd1);
        wr_reg(3'd1, 32'h2);
        rd_reg(3'd1, v); chk("R9 pe cleared", v, 32'h8);
        chk("R9 irq low", {31'd0, irq}, 32'd0);

        // R8 zero next pointer, error interrupt off
        do_reset();
        desc(32'h40, 32'h100, 32'h380, 32'd4, 32'h0);
        wr_reg(3'd2, 32'h40);
        wr_reg(3'd0, mk(1, 0, 0, 0, 0, 1, 0, 2'd2, 4'd2));
        repeat (10) @(negedge clk);
        rd_reg(3'd1, v); chk("R8 zero next halts", v, 32'hA);
        chk("R8 irq masked", {31'd0, irq}, 32'd0);
        chk("R8 no data moved", 32'(log_n), 32'd0);

        // R5 size code 3 rejected
        do_reset();
        desc(32'h40, 32'h100, 32'h380, 32'd8, 32'h40);
        wr_reg(3'd2, 32'h40);
        wr_reg(3'd0, mk(1, 0, 0, 0, 0, 1, 0, 2'd3, 4'd2));
        repeat (10) @(negedge clk);
        rd_reg(3'd1, v); chk("R5 size 3 programming error", v, 32'hA);

        // R12 start from the descriptor register, R10 abort mid segment
        do_reset();
        for (int i = 0; i < 20; i++) poke(32'h100 + 32'(4 * i), $urandom);
        desc(32'h40, 32'h100, 32'h380, 32'd8, 32'h50);
        desc(32'h50, 32'h120, 32'h380, 32'd64, 32'h40);
        wr_reg(3'd2, 32'h50);
        wr_reg(3'd0, mk(1, 0, 0, 0, 0, 1, 0, 2'd2, 4'd4));
        wait_cnt(1, 3);
        rd_reg(3'd2, v); chk("R12 R11 descriptor reg", v, 32'h50);
        wr_reg(3'd0, mk(0, 1, 0, 0, 0, 1, 0, 2'd2, 4'd4));
        chk("R12 first word from second descriptor", log_d[0], shadow[32'h120 >> 2]);
        rd_reg(3'd1, v); chk("R10 abort halted", v, 32'h8);
        n0 = log_n;
        repeat (20) @(negedge clk);
        chk("R10 frozen after abort", 32'(log_n), 32'(n0));
    endtask

    initial begin
        bit timeout;
        int seed_dummy;
        timeout = 1'b0;
        seed_dummy = int'($urandom(32'h5EED));
        @(negedge clk);
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=expired expected=done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule